// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sequences accesses to four DRAM banks that share one column strobe. It keeps track of the open row in each page-mode bank and sorts every new request into one of three classes. A page hit starts directly with the column phase. A page miss first precharges and then runs a full row and column cycle. A bank switch, or a bank with no open row, runs a full cycle straight away. The block drives one row strobe per bank, the shared column strobe, a row/column address-multiplexer select, the two DRAM address bits that step during a burst, and a one-clock acknowledge for each data beat.

The requester pulses `req` for one clock while no access is in flight. With that pulse it presents the address, the read/write flag, the size code and a one-hot bank select that an external decoder has already produced. Each bank has its own static configuration: page-mode enable, page size, precharge length, extra write wait on hits, burst enable, first-beat length and follow-on beat length. A line-fill request (size 2'b11) to a bank with burst enabled runs one full access and then three column-only beats.

Top module: `dram_page_seq`

## Requirements
- R1: After reset, `ras` and `cas` are all 0, `ack` is 0 and no bank has an open row, so the first access to any bank runs a full row-then-column cycle.
- R2: While idle, the row strobe of the last bank accessed stays 1 if that bank has page mode enabled, and it stays so until a request to another bank is accepted. After an access to a bank without page mode, all row strobes are 0 while idle.
- R3: A request that is neither a hit nor a miss negates every other bank's row strobe in the clock after acceptance. That clock is a single row phase (target `ras` bit 1, `row_sel`=1, `cas`=0), and the column phase follows it.
- R4: A page hit (same page-mode bank as the previous access, same page) puts `cas`=1 and `row_sel`=0 in the clock right after acceptance, with the bank's row strobe still asserted.
- R5: Two addresses are in the same page when they agree in every bit at or above position 9+S, where S is the bank's 2-bit page-size code (512 B to 4 KB pages).
- R6: A page miss (same page-mode bank, different page) holds all row strobes at 0 for max(P,1) clocks, P being the bank's precharge field, and then runs a row phase and a column phase.
- R7: A write that hits the page in a bank with write delay set keeps `cas` one clock longer in its first beat.
- R8: A request with size 2'b11 to a bank with burst enabled produces four column beats, with one clock of `cas`=0 (row strobe held) between consecutive beats. Any other size, or burst disabled, gives a single beat.
- R9: `col_bits` during beat k (k = 0..3) equals request address bits [3:2] plus k, modulo 4.
- R10: The first beat holds `cas` for max(A,1) clocks (plus R7), and each follow-on beat holds it for max(B,1) clocks. A and B are the bank's separate first-beat and beat-length fields.
- R11: `ack` is 1 for exactly the last `cas` clock of every beat, which gives four acknowledges for a burst.
- R12: `row_sel` is 1 only during row phases, never together with `cas`.
- R13: The stored address of a bank is replaced on every access to that bank. After a miss to a new page, a later request to that new page on the same bank is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-clock request strobe, only while idle |
| addr | input | 32 | Request byte address |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Size code; 2'b11 = line fill |
| bank_sel | input | 4 | One-hot decoded bank select |
| cfg_page_en | input | 4 | Per-bank page-mode enable |
| cfg_page_sz | input | 8 | Per-bank 2-bit page-size code |
| cfg_pre | input | 16 | Per-bank 4-bit precharge length |
| cfg_wr_dly | input | 4 | Per-bank extra wait on hit writes |
| cfg_burst_en | input | 4 | Per-bank line-fill burst enable |
| cfg_acc_len | input | 16 | Per-bank 4-bit first-beat length |
| cfg_beat_len | input | 16 | Per-bank 4-bit follow-on beat length |
| ras | output | 4 | Per-bank row strobe, active high |
| cas | output | 1 | Shared column strobe, active high |
| row_sel | output | 1 | 1 selects the row address at the multiplexer |
| ack | output | 1 | One-clock acknowledge per data beat |
| col_bits | output | 2 | DRAM address bits [3:2] for the current beat |

## Verification
The properties assume that `req` is pulsed only while no access is in flight and that `bank_sel` is one-hot whenever `req` is high. They also assume the configuration inputs do not change during an access. The bench issues a new request only after its model's queue of expected clocks is empty and the design has shown one idle clock. It draws bank selects only from one-hot values and sets the configuration once, before reset is released. Directed requests place addresses on both sides of each bank's page boundary and misalign burst start addresses so the beat address wraps.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int ADDR_W    = 32;
  localparam int LEN_W     = 4;
  localparam int CNT_W     = LEN_W + 1;
  localparam int PAGE_BASE = 9;

  typedef enum logic [1:0] {
    CLS_FULL = 2'd0,
    CLS_HIT  = 2'd1,
    CLS_MISS = 2'd2
  } acc_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ROW  = 3'd2,
    ST_COL  = 3'd3,
    ST_GAP  = 3'd4
  } seq_st_e;

  // Same page when all bits from PAGE_BASE+code upward agree.
  function automatic logic same_page(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [1:0]        code);
    int unsigned sh;
    sh = PAGE_BASE + int'(code);
    return (a >> sh) == (b >> sh);
  endfunction

  // A programmed length of zero behaves as one clock.
  function automatic logic [CNT_W-1:0] eff_len(input logic [LEN_W-1:0] x);
    return (x == '0) ? CNT_W'(1) : {1'b0, x};
  endfunction

endpackage

// File: rtl/dram_row_tracker.sv
module dram_row_tracker
  import dram_seq_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BW-1:0]     idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic              page_en_sel,
  input  logic [1:0]        page_code,
  output acc_cls_e          cls,
  output logic              open_v,
  output logic [BW-1:0]     open_b
);

  logic [ADDR_W-1:0] last_q [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_last
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_q[g] <= '0;
      end else if (accept && idx == BW'(g)) begin
        last_q[g] <= addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_v <= 1'b0;
      open_b <= '0;
    end else if (accept) begin
      open_v <= page_en_sel;
      open_b <= idx;
    end
  end

  always_comb begin
    cls = CLS_FULL;
    if (open_v && open_b == idx && page_en_sel) begin
      cls = same_page(addr, last_q[idx], page_code) ? CLS_HIT : CLS_MISS;
    end
  end

endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
  import dram_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  acc_cls_e         cls,
  input  logic             wr,
  input  logic             wdly,
  input  logic             burst,
  input  logic [LEN_W-1:0] pre_len,
  input  logic [LEN_W-1:0] acc_len,
  input  logic [LEN_W-1:0] beat_len,
  input  logic [1:0]       col_base,
  output logic             busy,
  output logic             ras_on,
  output logic             cas,
  output logic             row_sel,
  output logic             ack,
  output logic [1:0]       col
);

  seq_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       beat;
  logic [1:0]       last_beat;
  logic [1:0]       base_q;
  logic [CNT_W-1:0] first_q;
  logic [CNT_W-1:0] beatl_q;
  logic             beat_done;

  assign beat_done = (st == ST_COL) && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      beat      <= '0;
      last_beat <= '0;
      base_q    <= '0;
      first_q   <= '0;
      beatl_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          base_q    <= col_base;
          beat      <= '0;
          last_beat <= burst ? 2'd3 : 2'd0;
          first_q   <= eff_len(acc_len);
          beatl_q   <= eff_len(beat_len);
          unique case (cls)
            CLS_HIT: begin
              st  <= ST_COL;
              cnt <= eff_len(acc_len) + {{LEN_W{1'b0}}, wr & wdly};
            end
            CLS_MISS: begin
              st  <= ST_PRE;
              cnt <= eff_len(pre_len);
            end
            default: st <= ST_ROW;
          endcase
        end
        ST_PRE: begin
          if (cnt == CNT_W'(1)) st <= ST_ROW;
          else                  cnt <= cnt - CNT_W'(1);
        end
        ST_ROW: begin
          st  <= ST_COL;
          cnt <= first_q;
        end
        ST_COL: begin
          if (beat_done) begin
            if (beat == last_beat) begin
              st <= ST_IDLE;
            end else begin
              st   <= ST_GAP;
              beat <= beat + 2'd1;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_GAP: begin
          st  <= ST_COL;
          cnt <= beatl_q;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign ras_on  = (st == ST_ROW) || (st == ST_COL) || (st == ST_GAP);
  assign cas     = (st == ST_COL);
  assign row_sel = (st == ST_ROW);
  assign ack     = beat_done;
  assign col     = base_q + beat;

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr,
  input  logic [1:0]             size,
  input  logic [NBANK-1:0]       bank_sel,
  input  logic [NBANK-1:0]       cfg_page_en,
  input  logic [NBANK*2-1:0]     cfg_page_sz,
  input  logic [NBANK*LEN_W-1:0] cfg_pre,
  input  logic [NBANK-1:0]       cfg_wr_dly,
  input  logic [NBANK-1:0]       cfg_burst_en,
  input  logic [NBANK*LEN_W-1:0] cfg_acc_len,
  input  logic [NBANK*LEN_W-1:0] cfg_beat_len,
  output logic [NBANK-1:0]       ras,
  output logic                   cas,
  output logic                   row_sel,
  output logic                   ack,
  output logic [1:0]             col_bits
);

  logic [BW-1:0] idx;
  logic          accept;
  acc_cls_e      acc_cls;
  logic          open_v;
  logic [BW-1:0] open_b;
  logic          fsm_busy;
  logic          ras_on;
  logic          is_burst;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (bank_sel[i]) idx = BW'(i);
    end
  end

  assign accept   = req && !fsm_busy;
  assign is_burst = cfg_burst_en[idx] && (size == 2'b11);

  dram_row_tracker #(.NBANK(NBANK)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .idx         (idx),
    .addr        (addr),
    .page_en_sel (cfg_page_en[idx]),
    .page_code   (cfg_page_sz[idx*2 +: 2]),
    .cls         (acc_cls),
    .open_v      (open_v),
    .open_b      (open_b)
  );

  dram_cycle_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .cls      (acc_cls),
    .wr       (wr),
    .wdly     (cfg_wr_dly[idx]),
    .burst    (is_burst),
    .pre_len  (cfg_pre[idx*LEN_W +: LEN_W]),
    .acc_len  (cfg_acc_len[idx*LEN_W +: LEN_W]),
    .beat_len (cfg_beat_len[idx*LEN_W +: LEN_W]),
    .col_base (addr[3:2]),
    .busy     (fsm_busy),
    .ras_on   (ras_on),
    .cas      (cas),
    .row_sel  (row_sel),
    .ack      (ack),
    .col      (col_bits)
  );

  // During an access the tracker's open bank is the bank being served.
  for (genvar g = 0; g < NBANK; g++) begin : g_ras
    assign ras[g] = fsm_busy ? (ras_on && open_b == BW'(g))
                             : (open_v && open_b == BW'(g));
  end

endmodule

module dram_page_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input acc_cls_e         acc_cls,
  input logic             fsm_busy,
  input logic [NBANK-1:0] ras,
  input logic             cas,
  input logic             row_sel,
  input logic             ack
);

  // R3
  ras_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ras));

  // R2
  idle_ras_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsm_busy && $past(!fsm_busy) && !$past(accept)) |-> $stable(ras));

  // R3
  full_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_cls == CLS_FULL) |=> (row_sel && !cas && $onehot(ras)));

  // R4
  hit_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_cls == CLS_HIT) |=> (cas && !row_sel && $onehot(ras)));

  // R6
  miss_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_cls == CLS_MISS) |=> (ras == '0 && !cas));

  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R11
  ack_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> cas);

  // R12
  rowsel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_sel |-> (!cas && ras != '0));

endmodule

bind dram_page_seq dram_page_seq_chk #(.NBANK(NBANK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .acc_cls  (acc_cls),
  .fsm_busy (fsm_busy),
  .ras      (ras),
  .cas      (cas),
  .row_sel  (row_sel),
  .ack      (ack)
);

// File: tb/sim_dram_page_seq.sv
`timescale 1ns/100ps
module sim_dram_page_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        wr = 1'b0;
  logic [1:0]  size = '0;
  logic [3:0]  bank_sel = '0;
  logic [3:0]  cfg_page_en, cfg_wr_dly, cfg_burst_en;
  logic [7:0]  cfg_page_sz;
  logic [15:0] cfg_pre, cfg_acc_len, cfg_beat_len;
  logic [3:0]  ras;
  logic        cas, row_sel, ack;
  logic [1:0]  col_bits;

  always #2.5 clk = ~clk;

  dram_page_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr), .size(size),
    .bank_sel(bank_sel), .cfg_page_en(cfg_page_en), .cfg_page_sz(cfg_page_sz),
    .cfg_pre(cfg_pre), .cfg_wr_dly(cfg_wr_dly), .cfg_burst_en(cfg_burst_en),
    .cfg_acc_len(cfg_acc_len), .cfg_beat_len(cfg_beat_len),
    .ras(ras), .cas(cas), .row_sel(row_sel), .ack(ack), .col_bits(col_bits)
  );

  // Bank configuration used for the whole run.
  int pe [4]  = '{1, 1, 0, 1};
  int psz[4]  = '{0, 3, 0, 1};
  int pre[4]  = '{2, 0, 1, 5};
  int wd [4]  = '{1, 0, 0, 1};
  int be [4]  = '{1, 1, 0, 0};
  int acc[4]  = '{2, 1, 3, 0};
  int bl [4]  = '{1, 3, 2, 2};

  typedef struct {
    logic [3:0] ras;
    logic       cas;
    logic       rs;
    logic       ack;
    logic [1:0] col;
    string      tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] last_a[4];
  bit   ov = 0;
  int   ob = 0;
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 0;

  function automatic int atleast1(int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic push_e(logic [3:0] r, logic c, logic s, logic a, logic [1:0] cl, string t);
    exp_t e;
    e.ras = r; e.cas = c; e.rs = s; e.ack = a; e.col = cl; e.tag = t;
    q.push_back(e);
  endtask

  // Behavioural model: lists every clock of the access the request will cause.
  task automatic plan(int b, logic [31:0] a, bit w, logic [1:0] sz);
    int sh = 9 + psz[b];
    bit same = ((a >> sh) == (last_a[b] >> sh));
    bit hit  = ov && ob == b && pe[b] != 0 && same;
    bit miss = ov && ob == b && pe[b] != 0 && !same;
    logic [3:0] oh = 4'b0001 << b;
    int nb = (be[b] != 0 && sz == 2'b11) ? 4 : 1;
    if (miss) for (int i = 0; i < atleast1(pre[b]); i++) push_e(4'b0, 0, 0, 0, 2'd0, "R6");
    if (!hit) push_e(oh, 0, 1, 0, 2'd0, "R3 R12");
    for (int k = 0; k < nb; k++) begin
      int len;
      logic [1:0] cl = a[3:2] + 2'(k);
      if (k > 0) push_e(oh, 0, 0, 0, 2'd0, "R8");
      len = (k == 0) ? atleast1(acc[b]) + ((hit && w && wd[b] != 0) ? 1 : 0) : atleast1(bl[b]);
      for (int j = 0; j < len; j++) begin
        string t;
        if (j == len - 1)  t = "R11 R9";
        else if (k > 0)    t = "R9 R10";
        else if (hit)      t = "R4 R5 R7 R13";
        else               t = "R10";
        push_e(oh, 1, 0, (j == len - 1), cl, t);
      end
    end
    last_a[b] = a;
    ov = (pe[b] != 0);
    ob = b;
  endtask

  task automatic compare();
    exp_t e;
    if (q.size() != 0) e = q.pop_front();
    else begin
      e.ras = ov ? (4'b0001 << ob) : 4'b0;
      e.cas = 0; e.rs = 0; e.ack = 0; e.col = 2'd0; e.tag = "R2";
    end
    vectors++;
    if (ras !== e.ras || cas !== e.cas || row_sel !== e.rs || ack !== e.ack ||
        (e.cas && col_bits !== e.col)) begin
      miscompares++;
      $display("FAIL %s t=%0t: ras=%b cas=%b row_sel=%b ack=%b col=%0d expected ras=%b cas=%b row_sel=%b ack=%b col=%0d",
               e.tag, $time, ras, cas, row_sel, ack, col_bits, e.ras, e.cas, e.rs, e.ack, e.col);
    end
  endtask

  // Wait until the model shows an idle clock, then present one request.
  task automatic do_req(int b, logic [31:0] a, bit w, logic [1:0] sz);
    bit was_empty;
    forever begin
      @(negedge clk);
      was_empty = (q.size() == 0);
      compare();
      req = 1'b0;
      if (was_empty) break;
    end
    req = 1'b1; addr = a; wr = w; size = sz; bank_sel = 4'b0001 << b;
    plan(b, a, w, sz);
  endtask

  task automatic drain();
    while (q.size() != 0) begin
      @(negedge clk); compare(); req = 1'b0;
    end
    repeat (2) begin @(negedge clk); compare(); end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      cfg_page_en[i]            = (pe[i] != 0);
      cfg_wr_dly[i]             = (wd[i] != 0);
      cfg_burst_en[i]           = (be[i] != 0);
      cfg_page_sz[i*2 +: 2]     = 2'(psz[i]);
      cfg_pre[i*4 +: 4]         = 4'(pre[i]);
      cfg_acc_len[i*4 +: 4]     = 4'(acc[i]);
      cfg_beat_len[i*4 +: 4]    = 4'(bl[i]);
      last_a[i]                 = '0;
    end
    repeat (3) @(negedge clk);
    // R1: strobes quiet during and right after reset
    vectors++;
    if (ras !== 4'b0 || cas !== 1'b0 || ack !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: ras=%b cas=%b ack=%b expected ras=0000 cas=0 ack=0", ras, cas, ack);
    end
    rst_n = 1'b1;
    // R1: first access to bank 0 must be a full cycle (model has no open row)
    do_req(0, 32'h100, 0, 2'b00);
    do_req(0, 32'h104, 0, 2'b00);     // R4 hit
    do_req(0, 32'h108, 1, 2'b00);     // R7 hit write, extra wait
    do_req(0, 32'h300, 0, 2'b00);     // R5 R6 512 B page boundary crossed
    do_req(0, 32'h3FC, 1, 2'b00);     // R13 hit on new page
    do_req(1, 32'h000, 0, 2'b00);     // R3 bank switch
    do_req(1, 32'hF00, 0, 2'b00);     // R5 4 KB page hit
    do_req(1, 32'h1000, 0, 2'b00);    // R6 precharge field 0 acts as 1
    do_req(2, 32'h010, 0, 2'b00);     // R2 no page mode
    do_req(2, 32'h014, 1, 2'b00);     // R2 full again
    do_req(0, 32'h038, 0, 2'b11);     // R8 R9 burst, column wraps
    do_req(0, 32'h020, 1, 2'b11);     // R7 R8 burst hit write
    do_req(3, 32'h400, 0, 2'b11);     // R8 burst disabled, single beat
    do_req(3, 32'h7FC, 1, 2'b00);     // R5 1 KB page hit with write delay
    do_req(3, 32'h800, 0, 2'b00);     // R6 long precharge
    do_req(0, 32'h020, 0, 2'b00);     // R3 switch back
    do_req(0, 32'h010, 0, 2'b00);     // R13 hit using updated address
    for (int n = 0; n < 250; n++) begin
      int b = $urandom_range(0, 3);
      logic [31:0] a = $urandom & 32'h0000_1FFC;
      bit w = $urandom_range(0, 1);
      logic [1:0] sz = 2'($urandom_range(0, 3));
      do_req(b, a, w, sz);
      repeat ($urandom_range(0, 2)) begin @(negedge clk); compare(); req = 1'b0; end
    end
    drain();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

endmodule